// File: doc/BRIEF.md
# Serial Control-Register Slave with Auto-Incrementing Pointer

This block lets an external two-wire bus master (I2C protocol, up to 400 kHz) set and read a small bank of 8-bit control registers. Both bus lines are sampled with the system clock. Each line passes through a two-flop synchroniser and then a glitch filter. Edge events on the filtered lines mark the START, REPEATED START and STOP conditions and the SCL clock edges. The slave answers one 7-bit address. The upper five bits of that address are a parameter and the two low bits come from a strap input. The slave drives the SDA line only through an open-drain pull-low enable.

A write frame first loads an internal register pointer. After that, every data byte lands at the pointer, and the pointer then steps by one. A read frame returns the byte at the pointer and steps the pointer after each byte. The pointer survives a STOP, so a later read continues where the last transaction stopped. Pointer values past the last real register read back as a fixed dummy byte, and writes to them are dropped. The register contents are presented in parallel to the rest of the chip.

The controller is one state machine with these states:
- IDLE: no frame is in progress.
- ADDR: shifting in the address byte.
- ADDR_ACK: acknowledging the address.
- PTR: shifting in the pointer byte.
- PTR_ACK: acknowledging the pointer byte.
- WDATA: shifting in a data byte.
- WDATA_ACK: acknowledging a data byte.
- RDATA: shifting out a data byte.
- RACK: sampling the master's acknowledge.
- WAIT: ignoring the bus.

These transitions apply from any state:
- A START goes to ADDR.
- A valid STOP goes to IDLE.

These transitions happen at an SCL falling edge:
- ADDR goes to ADDR_ACK when the address matches, and to WAIT when it does not.
- PTR goes to PTR_ACK after eight bits.
- WDATA goes to WDATA_ACK after eight bits.
- ADDR_ACK goes to RDATA when R/W = 1, and to PTR when R/W = 0.
- PTR_ACK goes to WDATA.
- WDATA_ACK goes to WDATA.
- RDATA goes to RACK after eight bits.
- RACK goes to RDATA when the master acknowledged, and to WAIT when it did not.

Top module: `ser_reg_slave`

## Requirements
- R1: After reset every register reads 00h on `regs_out` and `sda_drive_low` is 0 (SDA released).
- R2: The slave answers the 7-bit address {5'b10010, `addr_strap[1:0]`}, sent MSB first and followed by the R/W bit (0 = write, 1 = read). When the address matches, the slave holds SDA low for the whole ninth clock.
- R3: When the address does not match, the slave gives no acknowledge. It leaves SDA released and ignores the bus until the next START or STOP, and all registers keep their values.
- R4: In a write frame, the byte after the address loads the pointer. Each following byte is written to the register at the pointer and acknowledged, and the pointer then increments by one. `regs_out[8*k+7:8*k]` holds register k.
- R5: In a read frame, the slave sends the register at the pointer MSB first and increments the pointer after each byte. A master acknowledge (SDA low on the ninth clock) continues the read. A master NACK makes the slave release SDA until a STOP or START.
- R6: The pointer keeps its value across a STOP. A read that starts right after a STOP begins at the pointer left by the previous transaction.
- R7: For pointer values of 02h and above, reads return FFh. Writes are acknowledged but change no register.
- R8: A STOP in the same SCL high period as a START is ignored, and the frame continues with the address byte.
- R9: A pulse on SDA or SCL shorter than `FILT_LEN` (default 4) system clocks is suppressed and does not disturb a frame.
- R10: A REPEATED START after the pointer byte begins a new address phase, so a read can follow a pointer write without a STOP.
- R11: The slave changes SDA only while SCL is low. Its drive is stable throughout each SCL high period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| addr_strap | input | 2 | Low bits of the slave address |
| sda_drive_low | output | 1 | 1 pulls SDA low (open-drain enable) |
| regs_out | output | 16 | Parallel register contents, register 0 in the low byte |

## Verification
The hardest case to reach from the ports is a STOP that arrives inside the same SCL high period as the START. The bench builds a custom frame opening with SCL held high: SDA falls, rises again, and only then does SCL drop. A correct slave then acknowledges the following address and write bytes, while a slave that obeyed the STOP stays silent. The glitch case is also hard to reach. There, a sub-threshold low pulse is placed on a 1-bit in the middle of a data byte, where a passed glitch would read as a START. The bench then checks the resulting register value and the acknowledge.

// File: rtl/ser_reg_pkg.sv
package ser_reg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_WAIT
    } slv_state_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/line_filter.sv
module line_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic filt_out
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic          s1, s2;
    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1       <= 1'b1;
            s2       <= 1'b1;
            filt_out <= 1'b1;
            run_cnt  <= '0;
        end else begin
            s1 <= raw_in;
            s2 <= s1;
            if (s2 != filt_out) begin
                if (run_cnt == CW'(FILT_LEN - 1)) begin
                    filt_out <= s2;
                    run_cnt  <= '0;
                end else begin
                    run_cnt <= run_cnt + 1'b1;
                end
            end else begin
                run_cnt <= '0;
            end
        end
    end

    // A flip of the filtered line needs the synchronised value held for several cycles (R9)
    assert_filter_settled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_out != $past(filt_out)) |-> ($past(s2, 2) == filt_out));

endmodule

// File: rtl/bus_events.sv
module bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic ev_start,
    output logic ev_stop,
    output logic ev_rise,
    output logic ev_fall
);
    logic scl_q, sda_q, start_this_high;
    logic stop_raw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q           <= 1'b1;
            sda_q           <= 1'b1;
            start_this_high <= 1'b0;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
            if (ev_start)
                start_this_high <= 1'b1;
            else if (ev_fall)
                start_this_high <= 1'b0;
        end
    end

    always_comb begin
        ev_start = scl_f && scl_q && sda_q && !sda_f;
        stop_raw = scl_f && scl_q && !sda_q && sda_f;
        ev_stop  = stop_raw && !start_this_high;
        ev_rise  = scl_f && !scl_q;
        ev_fall  = !scl_f && scl_q;
    end

endmodule

// File: rtl/reg_bank.sv
module reg_bank #(
    parameter int NUM_REGS = 2,
    parameter int IDX_W    = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    output logic [NUM_REGS*8-1:0] regs_flat
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [7:0] r;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                r <= 8'h00;
            else if (wr_en && wr_idx == IDX_W'(g))
                r <= wr_data;
        end

        assign regs_flat[g*8 +: 8] = r;

        // Write strobe aimed at this register stores the byte (R4)
        assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IDX_W'(g)) |=> (r == $past(wr_data)));
    end

    // Without a write strobe no register moves (R3)
    assert_regs_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_flat));

endmodule

// File: rtl/slv_fsm.sv
module slv_fsm
    import ser_reg_pkg::*;
#(
    parameter int          NUM_REGS = 2,
    parameter int          IDX_W    = 1,
    parameter int          STRAP_W  = 2,
    parameter logic [6-STRAP_W:0] ADDR_HI = 5'b10010,
    parameter logic [7:0]  DUMMY    = 8'hFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ev_start,
    input  logic                  ev_stop,
    input  logic                  ev_rise,
    input  logic                  ev_fall,
    input  logic                  sda_f,
    input  logic                  scl_f,
    input  logic [STRAP_W-1:0]    strap,
    input  logic [NUM_REGS*8-1:0] regs_flat,
    output logic                  wr_en,
    output logic [IDX_W-1:0]      wr_idx,
    output logic [7:0]            wr_data,
    output logic                  drive_low
);
    localparam logic [8:0] NREG9 = 9'(NUM_REGS);

    slv_state_e st;
    logic [3:0] bitcnt;
    logic [7:0] shreg;
    logic [7:0] ptr;
    logic       rw;
    logic       nack_q;
    logic       in_range;
    logic       byte_done;
    logic [7:0] rd_byte;
    logic [6:0] my_addr;

    always_comb begin
        my_addr   = {ADDR_HI, strap};
        in_range  = ({1'b0, ptr} < NREG9);
        rd_byte   = in_range ? regs_flat[{ptr[IDX_W-1:0], 3'b000} +: 8] : DUMMY;
        byte_done = ev_fall && (bitcnt == 4'd8);
        wr_en     = (st == ST_WDATA) && byte_done && in_range;
        wr_idx    = ptr[IDX_W-1:0];
        wr_data   = shreg;
    end

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            bitcnt <= '0;
            shreg  <= '0;
            ptr    <= '0;
            rw     <= 1'b0;
            nack_q <= 1'b1;
        end else if (ev_start) begin
            st     <= ST_ADDR;
            bitcnt <= '0;
        end else if (ev_stop) begin
            st <= ST_IDLE;
        end else begin
            unique case (st)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (ev_rise) begin
                        shreg  <= {shreg[6:0], sda_f};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_done) begin
                        bitcnt <= '0;
                        if (st == ST_ADDR) begin
                            if (shreg[7:1] == my_addr) begin
                                rw <= shreg[0];
                                st <= ST_ADDR_ACK;
                            end else begin
                                st <= ST_WAIT;
                            end
                        end else if (st == ST_PTR) begin
                            ptr <= shreg;
                            st  <= ST_PTR_ACK;
                        end else begin
                            ptr <= ptr + 8'd1;
                            st  <= ST_WDATA_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (ev_fall) begin
                        bitcnt <= '0;
                        if (rw) begin
                            shreg <= rd_byte;
                            st    <= ST_RDATA;
                        end else begin
                            st <= ST_PTR;
                        end
                    end
                end
                ST_PTR_ACK, ST_WDATA_ACK: begin
                    if (ev_fall) begin
                        bitcnt <= '0;
                        st     <= ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (ev_rise) begin
                        bitcnt <= bitcnt + 4'd1;
                    end else if (ev_fall) begin
                        if (bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            ptr    <= ptr + 8'd1;
                            st     <= ST_RACK;
                        end else begin
                            shreg <= {shreg[6:0], 1'b0};
                        end
                    end
                end
                ST_RACK: begin
                    if (ev_rise) begin
                        nack_q <= sda_f;
                    end else if (ev_fall) begin
                        if (!nack_q) begin
                            shreg <= rd_byte;
                            st    <= ST_RDATA;
                        end else begin
                            st <= ST_WAIT;
                        end
                    end
                end
                ST_IDLE, ST_WAIT: begin
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Output decode
    always_comb begin
        drive_low = 1'b0;
        unique case (st)
            ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: drive_low = 1'b1;
            ST_RDATA:                              drive_low = !shreg[7];
            default:                               drive_low = 1'b0;
        endcase
    end

    // Slave starts pulling SDA only while SCL is low (R11)
    assert_drive_rises_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_low) |-> !scl_f);

    // Each accepted data byte steps the pointer by one (R4)
    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ptr == $past(ptr) + 8'd1));

    // A valid STOP always returns the machine to idle with SDA released (R3)
    assert_stop_releases_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stop && !ev_start) |=> (st == ST_IDLE && !drive_low));

endmodule

// File: rtl/ser_reg_slave.sv
module ser_reg_slave #(
    parameter int                 NUM_REGS = 2,
    parameter int                 FILT_LEN = 4,
    parameter int                 STRAP_W  = 2,
    parameter logic [6-STRAP_W:0] ADDR_HI  = 5'b10010,
    parameter logic [7:0]         DUMMY    = 8'hFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_in,
    input  logic                  sda_in,
    input  logic [STRAP_W-1:0]    addr_strap,
    output logic                  sda_drive_low,
    output logic [NUM_REGS*8-1:0] regs_out
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic scl_f, sda_f;
    logic ev_start, ev_stop, ev_rise, ev_fall;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_data;

    line_filter #(.FILT_LEN(FILT_LEN)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .raw_in(scl_in), .filt_out(scl_f));

    line_filter #(.FILT_LEN(FILT_LEN)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .raw_in(sda_in), .filt_out(sda_f));

    bus_events u_events (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
        .ev_start(ev_start), .ev_stop(ev_stop), .ev_rise(ev_rise), .ev_fall(ev_fall));

    slv_fsm #(
        .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .STRAP_W(STRAP_W),
        .ADDR_HI(ADDR_HI), .DUMMY(DUMMY)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .ev_start(ev_start), .ev_stop(ev_stop), .ev_rise(ev_rise), .ev_fall(ev_fall),
        .sda_f(sda_f), .scl_f(scl_f), .strap(addr_strap), .regs_flat(regs_out),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .drive_low(sda_drive_low));

    reg_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .regs_flat(regs_out));

endmodule

// File: tb/sim_ser_reg_slave.sv
module sim_ser_reg_slave;
    localparam int Q  = 20;
    localparam int GL = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  strap = 2'b01;
    logic        drive;
    logic [15:0] regs;
    logic        sda_line;
    int          checks = 0;
    int          errors = 0;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~drive;

    ser_reg_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .addr_strap(strap), .sda_drive_low(drive), .regs_out(regs));

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    // gbit: bit position that gets a short low glitch while SCL is high (-1 for none)
    task automatic send_byte(input logic [7:0] b, input int gbit, output logic acked);
        logic d0;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q);
            scl_m = 1'b1; wq(Q);
            if (i == gbit) begin
                sda_m = 1'b0; wq(GL);
                sda_m = 1'b1;
            end
            wq(Q);
            scl_m = 1'b0; wq(Q);
        end
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(2);
        d0 = drive;
        wq(Q - 2);
        acked = !sda_line;
        wq(Q - 2);
        chk("R11 ack drive stable over high", {31'b0, drive}, {31'b0, d0});
        wq(2);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] d, inout int unstable);
        logic s0;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            sda_m = 1'b1; wq(Q);
            scl_m = 1'b1; wq(2);
            s0 = sda_line;
            wq(2 * Q - 4);
            if (sda_line !== s0) unstable++;
            d = {d[6:0], s0};
            wq(2);
            scl_m = 1'b0; wq(Q);
        end
        sda_m = nack; wq(Q);
        scl_m = 1'b1; wq(2 * Q);
        scl_m = 1'b0; wq(Q);
        sda_m = 1'b1;
    endtask

    task automatic t_reset();
        chk("R1 regs after reset", {16'b0, regs}, 32'h0);
        chk("R1 sda released after reset", {31'b0, drive}, 32'h0);
    endtask

    task automatic t_write_burst();
        logic a0, a1, a2, a3;
        bus_start();
        send_byte(8'h92, -1, a0);
        send_byte(8'h00, -1, a1);
        send_byte(8'hA5, -1, a2);
        send_byte(8'h3C, -1, a3);
        bus_stop();
        chk("R2 address ack", {31'b0, a0}, 32'h1);
        chk("R4 pointer and data acks", {29'b0, a1, a2, a3}, 32'h7);
        chk("R4 burst write regs", {16'b0, regs}, 32'h3CA5);
    endtask

    task automatic t_mismatch();
        logic a0, a1, a2;
        bus_start();
        send_byte(8'h90, -1, a0);
        send_byte(8'h00, -1, a1);
        send_byte(8'h77, -1, a2);
        bus_stop();
        chk("R3 no ack on wrong address", {29'b0, a0, a1, a2}, 32'h0);
        chk("R3 regs untouched", {16'b0, regs}, 32'h3CA5);
    endtask

    task automatic t_strap();
        logic a0, a1;
        strap = 2'b10; wq(Q);
        bus_start(); send_byte(8'h92, -1, a0); bus_stop();
        bus_start(); send_byte(8'h94, -1, a1); bus_stop();
        strap = 2'b01; wq(Q);
        chk("R2 old strap address refused", {31'b0, a0}, 32'h0);
        chk("R2 new strap address acked", {31'b0, a1}, 32'h1);
    endtask

    task automatic t_read_rs();
        logic a0, a1, a2;
        logic [7:0] d0, d1;
        int unstable = 0;
        bus_start();
        send_byte(8'h92, -1, a0);
        send_byte(8'h00, -1, a1);
        bus_start();
        send_byte(8'h93, -1, a2);
        recv_byte(1'b0, d0, unstable);
        recv_byte(1'b1, d1, unstable);
        chk("R5 released after master nack", {31'b0, drive}, 32'h0);
        bus_stop();
        chk("R10 read address after repeated start acked", {31'b0, a2}, 32'h1);
        chk("R5 first read byte", {24'b0, d0}, 32'hA5);
        chk("R5 second read byte after increment", {24'b0, d1}, 32'h3C);
        chk("R11 read data stable while SCL high", unstable, 0);
    endtask

    task automatic t_ptr_persist();
        logic a0, a1, a2;
        logic [7:0] d0, d1;
        int unstable = 0;
        bus_start(); send_byte(8'h93, -1, a0); recv_byte(1'b1, d0, unstable); bus_stop();
        chk("R6 R7 read after stop continues at pointer 02h", {24'b0, d0}, 32'hFF);
        bus_start(); send_byte(8'h92, -1, a1); send_byte(8'h01, -1, a2); bus_stop();
        bus_start(); send_byte(8'h93, -1, a0); recv_byte(1'b1, d1, unstable); bus_stop();
        chk("R6 read after pointer-only frame", {24'b0, d1}, 32'h3C);
    endtask

    task automatic t_dummy();
        logic a0, a1, a2, a3;
        logic [7:0] d0;
        int unstable = 0;
        bus_start();
        send_byte(8'h92, -1, a0);
        send_byte(8'h01, -1, a1);
        send_byte(8'h11, -1, a2);
        send_byte(8'h99, -1, a3);
        bus_stop();
        chk("R7 write past last register acked", {31'b0, a3}, 32'h1);
        chk("R7 write past last register dropped", {16'b0, regs}, 32'h11A5);
        bus_start(); send_byte(8'h93, -1, a0); recv_byte(1'b1, d0, unstable); bus_stop();
        chk("R7 dummy read at pointer 03h", {24'b0, d0}, 32'hFF);
    endtask

    task automatic t_start_stop_same();
        logic a0, a1, a2;
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b0; wq(Q);
        send_byte(8'h92, -1, a0);
        send_byte(8'h00, -1, a1);
        send_byte(8'h5A, -1, a2);
        bus_stop();
        chk("R8 frame survives stop in start high", {29'b0, a0, a1, a2}, 32'h7);
        chk("R8 register written", {16'b0, regs}, 32'h115A);
    endtask

    task automatic t_glitch();
        logic a0, a1, a2;
        bus_start();
        send_byte(8'h92, -1, a0);
        send_byte(8'h01, -1, a1);
        send_byte(8'hC3, 7, a2);
        bus_stop();
        chk("R9 acks with glitched bit", {29'b0, a0, a1, a2}, 32'h7);
        chk("R9 glitch suppressed", {16'b0, regs}, 32'hC35A);
    endtask

    initial begin
        wq(5);
        rst_n = 1'b1;
        wq(5);
        t_reset();
        t_write_burst();
        t_mismatch();
        t_strap();
        t_read_rs();
        t_ptr_persist();
        t_dummy();
        t_start_stop_same();
        t_glitch();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule